// File: doc/BRIEF.md
# Two-Wire Serial Memory Page-Write Slave

This block is the write side of a two-wire serial memory slave. It watches the clock and data lines with an oversampling system clock and recognises START and STOP conditions. It then takes in a device select byte, a word address byte and any number of data bytes, and pulls the data line low in the ninth clock of each byte it accepts. Data bytes go into a page buffer. The word pointer advances only within its page, so a long burst wraps back to the first location of that page and does not spill into the next one.

A STOP that comes after at least one fully acknowledged data byte starts a timed internal programming cycle. When that cycle ends, every location that was loaded is copied into a behavioural memory array. The slave ignores the bus while the cycle runs, so a master can poll the device select byte until it is acknowledged again. A STOP that comes too early or in the middle of a byte drops the transfer and leaves the array untouched. A START at any point begins decoding again and discards whatever was loaded. A combinational peek port exposes the array, and a byte counter and a busy flag show the progress of each transfer.

Top module: `pagewr_slave`

## Requirements
- R1: After reset, busy is 0, sdaDrvLow is 0, bytesLoaded is 0 and every array location reads 0 on peekData.
- R2: The slave acknowledges a device select byte only if its upper seven bits equal DEV_ADDR and its least significant bit (direction) is 0. In that case sdaDrvLow is 1 while SCL is high in the ninth clock. Any other select byte gets no acknowledge, and the rest of that transfer is ignored until the next START.
- R3: After an accepted select byte, the word address byte and every data byte are acknowledged in their ninth clock, and the acknowledge is raised only while SCL is low.
- R4: Each data byte is stored at the word pointer. The low log2(PAGE_BYTES) pointer bits then increment modulo PAGE_BYTES, and the upper bits never change. With 64-byte pages, 12 bytes sent from offset 60 land at offsets 60..63 and then 0..7, and offsets 8..59 keep their old values.
- R5: A STOP that arrives once the last data byte's acknowledge clock has ended, with no SCL high seen since other than the one that carries the STOP, commits the transfer if at least one data byte was loaded. busy then stays high for exactly BUSY_CYC clock cycles. The array keeps its old contents while busy is high and holds the loaded bytes once busy falls. When one location is written more than once in a transfer, the last byte wins.
- R6: A STOP that arrives before any acknowledged data byte, or after two or more SCL high phases of an unfinished byte, commits nothing. busy stays 0, bytesLoaded returns to 0 and the array is unchanged.
- R7: While busy is high, START, STOP and every bus bit are ignored. sdaDrvLow stays 0 and bytesLoaded stays frozen.
- R8: A START or repeated START while not busy clears bytesLoaded to 0 and discards the bytes loaded so far, which are never written.
- R9: bytesLoaded counts the data bytes acknowledged since the last START, one step at a time, and saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin (wired level) |
| sdaDrvLow | output | 1 | 1 pulls the data line low (acknowledge) |
| busy | output | 1 | High during the internal programming cycle |
| bytesLoaded | output | 8 | Data bytes acknowledged since the last START, saturating |
| peekAddr | input | ADDR_W | Array location to observe |
| peekData | output | 8 | Array contents at peekAddr |

## Verification
Two events can land in the same decision cycle. One is the first SCL rise after a data acknowledge, which the receive shifter treats as a new bit. The other is the STOP that follows on that same high phase. The design must count such a STOP as a commit, yet count a STOP after two or more SCL highs as an abort. The bench provokes both: it sends a normal STOP, and it sends STOPs after one to six extra bits, some directed and some random. It judges the outcome from busy, from the measured busy length and from a full comparison of the array against a model kept in the bench.

// File: rtl/pagewr_pkg.sv
`timescale 1ns/1ps
package pagewr_pkg;

  // Strobes from the bus control to the datapath, one cycle each.
  typedef struct packed {
    logic shiftEn;  // take bitVal into the receive shifter
    logic bitVal;   // sampled data line level
    logic clrPage;  // drop loaded bytes and clear the count
    logic ldAddr;   // receive shifter holds the word address
    logic stData;   // receive shifter holds an accepted data byte
    logic commit;   // copy loaded bytes into the array
  } pwStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_DEVACK, ST_WADR,
    ST_WADRACK, ST_DATA, ST_DATAACK, ST_BUSY
  } pwState_t;

endpackage

// File: rtl/pagewr_ctrl.sv
`timescale 1ns/1ps
module pagewr_ctrl
  import pagewr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int unsigned BUSY_CYC = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic [7:0] bytesLoaded,
  output pwStrobe_t  strobe,
  output logic       ackLow,
  output logic       busy
);
  localparam int TMR_W = $clog2(BUSY_CYC + 1);

  logic [2:0] sclPipe, sdaPipe;
  pwState_t state, stateN;
  logic [3:0] bitCnt, bitN;
  logic [TMR_W-1:0] timer, tmrN;
  logic ackN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[1:0], scl};
      sdaPipe <= {sdaPipe[1:0], sdaIn};
    end
  end

  logic sclNow, sclOld, sdaNow, sdaOld;
  assign sclNow = sclPipe[1];
  assign sclOld = sclPipe[2];
  assign sdaNow = sdaPipe[1];
  assign sdaOld = sdaPipe[2];

  logic sclRise, sclFall, startSeen, stopSeen;
  assign sclRise   = sclNow & ~sclOld;
  assign sclFall   = ~sclNow & sclOld;
  assign startSeen = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopSeen  = sclNow & sclOld & ~sdaOld & sdaNow;

  always_comb begin
    stateN = state;
    bitN   = bitCnt;
    ackN   = ackLow;
    tmrN   = timer;
    strobe = '0;
    strobe.bitVal = sdaNow;
    if (state == ST_BUSY) begin
      if (timer == TMR_W'(BUSY_CYC - 1)) begin
        strobe.commit = 1'b1;
        stateN = ST_IDLE;
        tmrN   = '0;
      end else begin
        tmrN = timer + 1'b1;
      end
    end else if (startSeen) begin
      stateN = ST_DEV;
      bitN   = '0;
      ackN   = 1'b0;
      strobe.clrPage = 1'b1;
    end else if (stopSeen) begin
      ackN = 1'b0;
      bitN = '0;
      if (state == ST_DATA && bitCnt <= 4'd1 && bytesLoaded != 8'd0) begin
        stateN = ST_BUSY;
        tmrN   = '0;
      end else begin
        stateN = ST_IDLE;
        strobe.clrPage = 1'b1;
      end
    end else begin
      case (state)
        ST_DEV, ST_WADR, ST_DATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            strobe.shiftEn = 1'b1;
            bitN = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitN = '0;
            if (state == ST_DEV) begin
              if (rxByte == {DEV_ADDR, 1'b0}) begin
                ackN   = 1'b1;
                stateN = ST_DEVACK;
              end else begin
                stateN = ST_IDLE;
              end
            end else begin
              ackN   = 1'b1;
              stateN = (state == ST_WADR) ? ST_WADRACK : ST_DATAACK;
            end
          end
        end
        ST_DEVACK: if (sclFall) begin
          ackN = 1'b0;
          stateN = ST_WADR;
        end
        ST_WADRACK: if (sclFall) begin
          ackN = 1'b0;
          strobe.ldAddr = 1'b1;
          stateN = ST_DATA;
        end
        ST_DATAACK: if (sclFall) begin
          ackN = 1'b0;
          strobe.stData = 1'b1;
          stateN = ST_DATA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackLow <= 1'b0;
      timer  <= '0;
    end else begin
      state  <= stateN;
      bitCnt <= bitN;
      ackLow <= ackN;
      timer  <= tmrN;
    end
  end

  assign busy = (state == ST_BUSY);

endmodule

// File: rtl/pagewr_dp.sv
`timescale 1ns/1ps
module pagewr_dp
  import pagewr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobe_t         strobe,
  output logic [7:0]        rxByte,
  output logic [7:0]        bytesLoaded,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [7:0]        peekData
);
  localparam int OFF_W     = $clog2(PAGE_BYTES);
  localparam int MEM_DEPTH = 1 << ADDR_W;

  logic [7:0]            shiftReg;
  logic [ADDR_W-1:0]     wordPtr;
  logic [PAGE_BYTES-1:0] loadedMask;
  logic [7:0]            byteCnt;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [7:0]            memArr  [MEM_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      wordPtr    <= '0;
      loadedMask <= '0;
      byteCnt    <= '0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {shiftReg[6:0], strobe.bitVal};
      if (strobe.clrPage) begin
        loadedMask <= '0;
        byteCnt    <= '0;
      end
      if (strobe.ldAddr) wordPtr <= ADDR_W'(shiftReg);
      if (strobe.stData) begin
        loadedMask[wordPtr[OFF_W-1:0]] <= 1'b1;
        wordPtr[OFF_W-1:0] <= wordPtr[OFF_W-1:0] + 1'b1;
        if (byteCnt != 8'hFF) byteCnt <= byteCnt + 1'b1;
      end
      if (strobe.commit) loadedMask <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.stData) pageBuf[wordPtr[OFF_W-1:0]] <= shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < MEM_DEPTH; a++) memArr[a] <= '0;
    end else if (strobe.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (loadedMask[i]) memArr[{wordPtr[ADDR_W-1:OFF_W], OFF_W'(i)}] <= pageBuf[i];
      end
    end
  end

  assign rxByte      = shiftReg;
  assign bytesLoaded = byteCnt;
  assign peekData    = memArr[peekAddr];

endmodule

// File: rtl/pagewr_slave.sv
`timescale 1ns/1ps
module pagewr_slave
  import pagewr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR   = 7'h50,
  parameter int          ADDR_W     = 8,
  parameter int          PAGE_BYTES = 64,
  parameter int unsigned BUSY_CYC   = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  output logic              sdaDrvLow,
  output logic              busy,
  output logic [7:0]        bytesLoaded,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [7:0]        peekData
);
  pwStrobe_t  strobe;
  logic [7:0] rxByte;

  pagewr_ctrl #(.DEV_ADDR(DEV_ADDR), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn),
    .rxByte(rxByte), .bytesLoaded(bytesLoaded),
    .strobe(strobe), .ackLow(sdaDrvLow), .busy(busy)
  );

  pagewr_dp #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rxByte(rxByte), .bytesLoaded(bytesLoaded),
    .peekAddr(peekAddr), .peekData(peekData)
  );

endmodule

// File: rtl/pagewr_checks.sv
`timescale 1ns/1ps
module pagewr_checks #(
  parameter int unsigned BUSY_CYC = 500000
) (
  input logic       clk,
  input logic       rstN,
  input logic       scl,
  input logic       sdaDrvLow,
  input logic       busy,
  input logic [7:0] bytesLoaded
);
  int unsigned busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else           busyLen <= 0;
  end

  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaDrvLow);  // R7
  AST_COUNT_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(bytesLoaded));  // R7
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == BUSY_CYC));  // R5
  AST_BUSY_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (bytesLoaded != 8'd0));  // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bytesLoaded) |-> (bytesLoaded == $past(bytesLoaded) + 8'd1 || bytesLoaded == 8'd0));  // R9
  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> !scl);  // R3

endmodule

bind pagewr_slave pagewr_checks #(.BUSY_CYC(BUSY_CYC)) u_checks (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaDrvLow(sdaDrvLow),
  .busy(busy), .bytesLoaded(bytesLoaded)
);

// File: tb/tb_pagewr_slave.sv
`timescale 1ns/1ps
module tb_pagewr_slave;
  localparam int BUSY = 2000;
  localparam int Q    = 5;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rstN = 1'b0, mScl = 1'b1, mSda = 1'b1;
  logic sdaDrvLow, busy, sdaLine;
  logic [7:0] bytesLoaded, peekData;
  logic [7:0] peekAddr = '0;
  assign sdaLine = mSda & ~sdaDrvLow;

  always #5 clk = ~clk;

  pagewr_slave #(.DEV_ADDR(DEV), .ADDR_W(8), .PAGE_BYTES(64), .BUSY_CYC(BUSY)) dut (
    .clk(clk), .rstN(rstN), .scl(mScl), .sdaIn(sdaLine), .sdaDrvLow(sdaDrvLow),
    .busy(busy), .bytesLoaded(bytesLoaded), .peekAddr(peekAddr), .peekData(peekData)
  );

  int nTests = 0, nFail = 0;
  bit done = 1'b0;
  logic [7:0] expMem [256];
  logic [7:0] pA[$];
  logic [7:0] pD[$];
  int runCnt = 0, lastRun = 0;

  always @(negedge clk) begin
    if (busy) runCnt <= runCnt + 1;
    else if (runCnt != 0) begin lastRun <= runCnt; runCnt <= 0; end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] nextAddr(input logic [7:0] a);
    return {a[7:6], a[5:0] + 6'd1};
  endfunction

  task automatic waitQ; repeat (Q) @(negedge clk); endtask

  task automatic busStart;
    if (!mScl) begin mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); end
    mSda = 1'b0; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic sendBit(input bit b);
    mSda = b; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ();
    ack = !sdaLine;
    waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic busStop;
    mSda = 1'b0; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b1; waitQ();
  endtask

  task automatic compareMem(input string req);
    int bad = 0, firstA = 0;
    @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      peekAddr = 8'(a); #1;
      if (peekData !== expMem[a]) begin
        if (bad == 0) firstA = a;
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("array mismatches (first at %0d)", firstA), bad, 0);
  endtask

  task automatic applyPending;
    foreach (pA[i]) expMem[pA[i]] = pD[i];
    pA.delete(); pD.delete();
  endtask

  task automatic loadBytes(input logic [7:0] waddr, input int n);
    bit a;
    logic [7:0] ptr, d;
    pA.delete(); pD.delete();
    busStart();
    sendByte({DEV, 1'b0}, a);
    check(a, "R2", "select ack", a, 1);
    sendByte(waddr, a);
    check(a, "R3", "word address ack", a, 1);
    ptr = waddr;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendByte(d, a);
      if (k < 3) check(a, "R3", "data ack", a, 1);
      pA.push_back(ptr); pD.push_back(d);
      ptr = nextAddr(ptr);
      if (k < 16) check(bytesLoaded == 8'(k + 1), "R9", "byte count", bytesLoaded, k + 1);
    end
  endtask

  task automatic finishCommit(input string req);
    check(busy, "R5", "busy after stop", busy, 1);
    compareMem("R5");
    while (busy) @(negedge clk);
    @(negedge clk);
    check(lastRun == BUSY, "R5", "busy length", lastRun, BUSY);
    applyPending();
    compareMem(req);
  endtask

  task automatic expectAbort(input string req);
    repeat (20) @(negedge clk);
    check(!busy, req, "no busy after abort", busy, 0);
    check(bytesLoaded == 0, req, "count after abort", bytesLoaded, 0);
    pA.delete(); pD.delete();
    compareMem(req);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL all watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    bit a;
    void'($urandom(32'd4242));
    foreach (expMem[i]) expMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    check(!busy, "R1", "reset busy", busy, 0);
    check(!sdaDrvLow, "R1", "reset drive", sdaDrvLow, 0);
    check(bytesLoaded == 0, "R1", "reset count", bytesLoaded, 0);
    compareMem("R1");
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R4: 12 bytes from offset 60 of page 1 wrap to offsets 0..7
    loadBytes(8'h7C, 12);
    check(bytesLoaded == 12, "R9", "count after burst", bytesLoaded, 12);
    busStop();
    finishCommit("R4");
    peekAddr = 8'h48; #1;
    check(peekData == 8'h00, "R4", "offset 8 untouched", peekData, 0);

    // R2: wrong device address and read direction are not acknowledged
    busStart();
    sendByte({DEV ^ 7'h01, 1'b0}, a);
    check(!a, "R2", "wrong address ack", a, 0);
    sendByte(8'h10, a);
    check(!a, "R2", "ignored byte ack", a, 0);
    busStop();
    busStart();
    sendByte({DEV, 1'b1}, a);
    check(!a, "R2", "read direction ack", a, 0);
    busStop();
    expectAbort("R2");

    // R6: stop after the word address only
    busStart();
    sendByte({DEV, 1'b0}, a);
    sendByte(8'h20, a);
    busStop();
    expectAbort("R6");
    // R6: stop inside a data byte after one good byte
    loadBytes(8'h30, 1);
    for (int b = 0; b < 3; b++) sendBit(1'b1);
    busStop();
    expectAbort("R6");

    // R7: bus ignored during busy
    loadBytes(8'hC5, 2);
    busStop();
    busStart();
    sendByte({DEV, 1'b0}, a);
    check(!a, "R7", "select ack while busy", a, 0);
    sendByte(8'hC5, a);
    check(!a, "R7", "address ack while busy", a, 0);
    sendByte(8'hEE, a);
    check(!a, "R7", "data ack while busy", a, 0);
    busStop();
    check(bytesLoaded == 2, "R7", "count frozen while busy", bytesLoaded, 2);
    finishCommit("R7");

    // R8: repeated start discards loaded bytes
    loadBytes(8'h05, 3);
    busStart();
    check(bytesLoaded == 0, "R8", "count after repeated start", bytesLoaded, 0);
    pA.delete(); pD.delete();
    sendByte({DEV, 1'b0}, a);
    sendByte(8'h90, a);
    for (int k = 0; k < 2; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      sendByte(d, a);
      pA.push_back(8'h90 + 8'(k)); pD.push_back(d);
    end
    busStop();
    finishCommit("R8");

    // R9: long burst saturates the count, last write wins after wrapping
    loadBytes(8'h80, 260);
    check(bytesLoaded == 255, "R9", "saturated count", bytesLoaded, 255);
    busStop();
    finishCommit("R9");

    // random transfers, some aborted inside a byte (R4, R5, R6)
    for (int t = 0; t < 6; t++) begin
      logic [7:0] wa;
      int n;
      bit abort;
      wa = 8'($urandom);
      n = 1 + int'($urandom % 20);
      abort = ($urandom % 3) == 0;
      loadBytes(wa, n);
      if (abort) begin
        int nb;
        nb = 1 + int'($urandom % 6);
        for (int b = 0; b < nb; b++) sendBit(1'($urandom));
        busStop();
        expectAbort("R6");
      end else begin
        busStop();
        finishCommit("R4");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule